// File: doc/BRIEF.md
# Character-Synchronous Receiver with Sync Hunt

This block turns a serial line bit stream, qualified by a bit clock enable, into parallel characters of 6, 7 or 8 bits. No start bits frame the characters. The receiver finds character phase itself: it slides a window over the incoming bits and compares each bit-aligned window with a programmable sync pattern. In STR mode a single match is enough to lock. In BSC mode the match must repeat on the following character boundary.

Once locked, the receiver withholds the sync characters that established phase. The first character that is not the sync pattern is delivered, and so is every character after it, sync characters included. Each delivered character lands in a holding buffer and raises a read-ready flag. A single sticky error flag records two faults: a character overrun, and a read issued with no character pending. An end-operation strobe, or leaving receive mode, drops character phase so that the next reception hunts again.

Top module: `sync_char_rx`

## Requirements
- R1: The first bit received for a character becomes bit 0 of `rd_data`, and later bits fill the higher positions in arrival order.
- R2: With `mode_bsc`=0, the receiver locks (`locked`=1) on the first bit-aligned window that equals the sync pattern. The locking sync and any sync characters that immediately follow it are not delivered.
- R3: With `mode_bsc`=1, one isolated sync match followed by a non-matching character does not lock. A match repeated on the next character boundary does lock.
- R4: After lock, the first non-sync character and every later character are delivered, including later sync characters.
- R5: With 6-bit framing a character is 6 bits and `rd_data`[7:6] reads 0. With 7-bit framing `rd_data`[7] reads 0. Sync matching uses only the active low-order bits of `sync_data`.
- R6: `sel_six` selects 6-bit framing and `sel_seven` selects 7-bit framing, each replacing the other. While `rx_enable`=0 framing returns to, and stays at, 8 bits.
- R7: If a character completes while `rd_ready`=1 and no `rd_req` is given in that cycle, `rx_err` is set and `rd_data` takes the new character.
- R8: An `rd_req` given while `rd_ready`=0 sets `rx_err`.
- R9: `rd_ready` clears on `rd_req` or `status_clr`. `rx_err` clears only on `status_clr`.
- R10: An `end_op` pulse, or `rx_enable`=0, clears `locked`, and the next reception hunts for sync again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive mode active |
| mode_bsc | input | 1 | 1: two consecutive matches needed to lock; 0: one match |
| sel_six | input | 1 | Strobe selecting 6-bit framing |
| sel_seven | input | 1 | Strobe selecting 7-bit framing |
| end_op | input | 1 | Strobe dropping character phase |
| sync_load | input | 1 | Loads `sync_data` into the sync pattern register |
| sync_data | input | 8 | Sync pattern value |
| bit_en | input | 1 | Qualifies `rx_bit` for one cycle |
| rx_bit | input | 1 | Serial line data |
| rd_req | input | 1 | Read strobe for the holding buffer |
| status_clr | input | 1 | Clears `rd_ready` and `rx_err` |
| rd_data | output | 8 | Holding buffer contents |
| rd_ready | output | 1 | Unread character present |
| rx_err | output | 1 | Sticky overrun or gap error |
| locked | output | 1 | Character phase established |

## Verification
Most internal faults show up as wrong values on `rd_data`. A wrong bit counter or window shift shows up on the first delivered character after lock, which arrives one character time after the sync. A faulty lock state machine either misses a lock, so the expected characters never arrive, or delivers a sync character that should have been withheld. A flag fault shows on `rd_ready` or `rx_err` at the edge that samples the last bit of a character, or one cycle after a read or clear strobe.

// File: rtl/scrx_pkg.sv
package scrx_pkg;
   // amount by which the active frame is shorter than the full character
   typedef enum logic [1:0] {
      FR_FULL  = 2'd0,
      FR_LESS1 = 2'd1,
      FR_LESS2 = 2'd2
   } frame_e;

   typedef enum logic [1:0] {
      PH_HUNT,
      PH_CONFIRM,
      PH_SKIP,
      PH_DATA
   } phase_e;
endpackage

// File: rtl/scrx_frame_ctl.sv
module scrx_frame_ctl
   import scrx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   rx_enable,
   input  logic   sel_six,
   input  logic   sel_seven,
   output frame_e frame
);
   always_ff @(posedge clk) begin
      if (!rst_n || !rx_enable) frame <= FR_FULL;
      else if (sel_six)         frame <= FR_LESS2;
      else if (sel_seven)       frame <= FR_LESS1;
   end

   assert_frame_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (frame == FR_FULL));
   assert_frame_six_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && sel_six) |=> (frame == FR_LESS2));
endmodule

// File: rtl/scrx_hunter.sv
module scrx_hunter
   import scrx_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter int STR_HITS = 1,
   parameter int BSC_HITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              end_op,
   input  logic              mode_bsc,
   input  logic              bit_en,
   input  logic              rx_bit,
   input  frame_e            frame,
   input  logic [CHAR_W-1:0] sync_pat,
   output logic              char_stb,
   output logic [CHAR_W-1:0] char_val,
   output logic              locked
);
   localparam int CNT_W   = $clog2(CHAR_W + 1);
   localparam int MAXHITS = (STR_HITS > BSC_HITS) ? STR_HITS : BSC_HITS;
   localparam int HIT_W   = $clog2(MAXHITS + 1);

   generate
      if (CHAR_W < 4) begin : g_bad_width
         $error("scrx_hunter: CHAR_W must be at least 4");
      end
      if (STR_HITS < 1 || BSC_HITS < 1) begin : g_bad_hits
         $error("scrx_hunter: hit counts must be at least 1");
      end
   endgenerate

   phase_e            phase;
   logic [CHAR_W-1:0] sr, sr_nx, mask, win;
   logic [CNT_W-1:0]  cnt, act_len;
   logic [HIT_W-1:0]  hits, need;
   logic              is_sync, last, drop;

   always_comb begin
      act_len = CNT_W'(CHAR_W) - CNT_W'(frame);
      sr_nx   = {rx_bit, sr[CHAR_W-1:1]};
      mask    = ~({CHAR_W{1'b1}} << act_len);
      win     = (sr_nx >> (CNT_W'(CHAR_W) - act_len)) & mask;
      is_sync = (win == (sync_pat & mask));
      last    = (cnt == act_len - CNT_W'(1));
      need    = mode_bsc ? HIT_W'(BSC_HITS) : HIT_W'(STR_HITS);
      drop    = !rx_enable || end_op;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || drop) begin
         phase <= PH_HUNT;
         sr    <= '0;
         cnt   <= '0;
         hits  <= '0;
      end else if (bit_en) begin
         sr <= sr_nx;
         unique case (phase)
            PH_HUNT: begin
               cnt <= '0;
               if (is_sync) begin
                  if (need <= HIT_W'(1)) phase <= PH_SKIP;
                  else begin
                     phase <= PH_CONFIRM;
                     hits  <= HIT_W'(1);
                  end
               end
            end
            PH_CONFIRM: begin
               if (last) begin
                  cnt <= '0;
                  if (!is_sync) begin
                     phase <= PH_HUNT;
                     hits  <= '0;
                  end else if (hits + HIT_W'(1) >= need) phase <= PH_SKIP;
                  else hits <= hits + HIT_W'(1);
               end else cnt <= cnt + CNT_W'(1);
            end
            PH_SKIP: begin
               if (last) begin
                  cnt <= '0;
                  if (!is_sync) phase <= PH_DATA;
               end else cnt <= cnt + CNT_W'(1);
            end
            default: begin
               if (last) cnt <= '0;
               else      cnt <= cnt + CNT_W'(1);
            end
         endcase
      end
   end

   assign char_stb = bit_en && !drop && last &&
                     ((phase == PH_SKIP && !is_sync) || phase == PH_DATA);
   assign char_val = win;
   assign locked   = (phase == PH_SKIP) || (phase == PH_DATA);

   assert_drop_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      end_op |=> !locked);
   assert_bsc_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HUNT && bit_en && !drop && mode_bsc && BSC_HITS > 1) |=> !locked);
   assert_no_stb_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !char_stb);
endmodule

// File: rtl/scrx_hold_buf.sv
module scrx_hold_buf #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_stb,
   input  logic [CHAR_W-1:0] char_val,
   input  logic              rd_req,
   input  logic              status_clr,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rd_ready,
   output logic              rx_err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_ready <= 1'b0;
         rx_err   <= 1'b0;
      end else begin
         if (char_stb) rd_data <= char_val;

         if (char_stb)                    rd_ready <= 1'b1;
         else if (status_clr || rd_req)   rd_ready <= 1'b0;

         if (status_clr) rx_err <= 1'b0;
         else if ((char_stb && rd_ready && !rd_req) || (rd_req && !rd_ready))
            rx_err <= 1'b1;
      end
   end

   assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && rd_ready && !rd_req && !status_clr) |=> rx_err);
   assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready && !status_clr) |=> rx_err);
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && !status_clr) |=> rx_err);
   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !char_stb) |=> !rd_ready);
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
   import scrx_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter int STR_HITS = 1,
   parameter int BSC_HITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              mode_bsc,
   input  logic              sel_six,
   input  logic              sel_seven,
   input  logic              end_op,
   input  logic              sync_load,
   input  logic [CHAR_W-1:0] sync_data,
   input  logic              bit_en,
   input  logic              rx_bit,
   input  logic              rd_req,
   input  logic              status_clr,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rd_ready,
   output logic              rx_err,
   output logic              locked
);
   frame_e            frame;
   logic [CHAR_W-1:0] sync_pat, char_val;
   logic              char_stb;

   always_ff @(posedge clk) begin
      if (!rst_n)         sync_pat <= '0;
      else if (sync_load) sync_pat <= sync_data;
   end

   scrx_frame_ctl u_frame (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
      .sel_six(sel_six), .sel_seven(sel_seven), .frame(frame)
   );

   scrx_hunter #(.CHAR_W(CHAR_W), .STR_HITS(STR_HITS), .BSC_HITS(BSC_HITS)) u_hunt (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .end_op(end_op),
      .mode_bsc(mode_bsc), .bit_en(bit_en), .rx_bit(rx_bit), .frame(frame),
      .sync_pat(sync_pat), .char_stb(char_stb), .char_val(char_val), .locked(locked)
   );

   scrx_hold_buf #(.CHAR_W(CHAR_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .char_stb(char_stb), .char_val(char_val),
      .rd_req(rd_req), .status_clr(status_clr), .rd_data(rd_data),
      .rd_ready(rd_ready), .rx_err(rx_err)
   );

   assert_high_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && frame == FR_LESS2) |=> (rd_data[CHAR_W-1:CHAR_W-2] == 2'b00));
endmodule

// File: tb/sync_char_rx_test.sv
module sync_char_rx_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_enable = 1'b0, mode_bsc = 1'b0, sel_six = 1'b0, sel_seven = 1'b0;
   logic       end_op = 1'b0, sync_load = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
   logic       rd_req = 1'b0, status_clr = 1'b0;
   logic [7:0] sync_data = 8'h00;
   logic [7:0] rd_data;
   logic       rd_ready, rx_err, locked;

   int   n_checks = 0, n_fails = 0;
   bit   auto_rd = 1'b0, done = 1'b0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_char_rx uut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .mode_bsc(mode_bsc),
      .sel_six(sel_six), .sel_seven(sel_seven), .end_op(end_op),
      .sync_load(sync_load), .sync_data(sync_data), .bit_en(bit_en),
      .rx_bit(rx_bit), .rd_req(rd_req), .status_clr(status_clr),
      .rd_data(rd_data), .rd_ready(rd_ready), .rx_err(rx_err), .locked(locked)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic strobe(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic load_sync(input logic [7:0] v);
      @(negedge clk); sync_data = v; sync_load = 1'b1;
      @(negedge clk); sync_load = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); rx_bit = b; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      @(negedge clk);
   endtask

   // driver: serialises LSB first, queues the expected delivery
   task automatic send_char(input logic [7:0] v, input int n, input bit expect_out);
      if (expect_out) exp_q.push_back(v & 8'((1 << n) - 1));
      for (int i = 0; i < n; i++) send_bit(v[i]);
   endtask

   // monitor: pops and compares every delivered character
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd && rd_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected char", rd_data, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R1 R4 R5 delivered char", rd_data, e);
            end
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_ready == 0 && rx_err == 0 && locked == 0, "reset state",
          {rd_ready, rx_err, locked}, 0);

      // STR lock with misaligned junk, repeated syncs withheld (R2, R4, R1)
      rx_enable = 1'b1; auto_rd = 1'b1;
      load_sync(8'h96);
      send_bit(1); send_bit(1); send_bit(1);
      send_char(8'h96, 8, 0);
      chk(locked == 1, "R2 STR single match locks", locked, 1);
      send_char(8'h96, 8, 0);
      send_char(8'hA5, 8, 1);
      send_char(8'h3C, 8, 1);
      send_char(8'h96, 8, 1);
      send_char(8'h01, 8, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all STR chars delivered", exp_q.size(), 0);

      // end_op drops phase (R10)
      strobe(end_op);
      chk(locked == 0, "R10 end_op drops phase", locked, 0);

      // BSC: single match then mismatch does not lock (R3)
      mode_bsc = 1'b1;
      load_sync(8'h32);
      send_char(8'h32, 8, 0);
      send_char(8'h5A, 8, 0);
      chk(locked == 0, "R3 single BSC match no lock", locked, 0);
      send_char(8'h32, 8, 0);
      chk(locked == 0, "R3 first of pair no lock", locked, 0);
      send_char(8'h32, 8, 0);
      chk(locked == 1, "R3 BSC pair locks", locked, 1);
      send_char(8'h10, 8, 1);
      send_char(8'h32, 8, 1);
      send_char(8'h02, 8, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all BSC chars delivered", exp_q.size(), 0);

      // overrun, read, gap, clear (R7, R8, R9)
      auto_rd = 1'b0;
      send_char(8'h11, 8, 0);
      chk(rd_ready == 1 && rx_err == 0, "R9 ready without error", {rd_ready, rx_err}, 2);
      send_char(8'h22, 8, 0);
      chk(rx_err == 1, "R7 overrun sets error", rx_err, 1);
      chk(rd_data == 8'h22, "R7 newest char held", rd_data, 8'h22);
      strobe(rd_req);
      chk(rd_ready == 0, "R9 read clears ready", rd_ready, 0);
      chk(rx_err == 1, "R9 read leaves error", rx_err, 1);
      strobe(status_clr);
      chk(rx_err == 0, "R9 status clear clears error", rx_err, 0);
      strobe(rd_req);
      chk(rx_err == 1, "R8 read with nothing pending", rx_err, 1);
      strobe(status_clr);
      send_char(8'h33, 8, 0);
      strobe(status_clr);
      chk(rd_ready == 0 && rx_err == 0, "R9 status clear clears ready",
          {rd_ready, rx_err}, 0);

      // leave receive mode, 6-bit framing (R10, R5, R6)
      rx_enable = 1'b0;
      @(negedge clk);
      chk(locked == 0, "R10 leaving receive drops phase", locked, 0);
      rx_enable = 1'b1; mode_bsc = 1'b0; auto_rd = 1'b1;
      strobe(sel_six);
      load_sync(8'hD6);
      send_char(8'h16, 6, 0);
      chk(locked == 1, "R5 6-bit sync on low bits", locked, 1);
      send_char(8'h2B, 6, 1);
      send_char(8'h3F, 6, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5 6-bit chars delivered", exp_q.size(), 0);

      // 7-bit selection replaces 6-bit (R6, R5)
      strobe(sel_seven);
      strobe(end_op);
      load_sync(8'h85);
      send_char(8'h05, 7, 0);
      send_char(8'h7E, 7, 1);
      send_char(8'h40, 7, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 7-bit chars delivered", exp_q.size(), 0);

      // re-entering receive returns to 8-bit framing (R6)
      rx_enable = 1'b0;
      @(negedge clk);
      rx_enable = 1'b1;
      load_sync(8'h96);
      send_char(8'h96, 8, 0);
      send_char(8'hC3, 8, 1);
      send_char(8'h81, 8, 1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 default 8-bit framing", exp_q.size(), 0);

      done = 1'b1;
      finish_run();
   end
endmodule